// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This block is the register and sequencing side of an SPI master. Software writes bytes through a 32-bit word-addressed register port, and the bytes collect in a transmit FIFO. Whenever the master-inhibit control bit is clear, the FIFO empties itself one byte at a time. Each byte goes through a valid/ready handshake to an external bit shifter, and the byte that the shifter returns is stored in a receive FIFO, which software then reads back. Clock generation, clock phase and polarity, and the bit shifting itself belong to the shifter. They are not part of this block.

A status word reports four fill conditions: transmit full, transmit empty, receive full and receive empty. Two occupancy registers report how many entries each FIFO holds. A register drives the active-low slave-select lines, and the number of lines is a parameter. Writing a key value to a dedicated register resets the whole block. Two self-clearing control bits empty either FIFO on its own. Three one-cycle event pulses go to a separate interrupt block: receive overrun, receive became full, and transmit became empty.

Top module: `spi_mm_ctrl`

## Requirements
- R1: After reset the status word reads 0x5, the control word reads 0, both occupancy registers read 0 and every slave-select output is high.
- R2: A write to byte offset 0x68 queues only bits [7:0]. Queued bytes leave on tx_byte in write order, each one when tx_valid and tx_ready are both high. No new byte is offered until rx_valid has returned the byte for the previous one.
- R3: Each returned byte is queued in the receive FIFO. A read at offset 0x6C returns the oldest byte in bits [7:0] and removes it. Offsets 0x74 (transmit) and 0x78 (receive) read the entry count minus one, or 0 when the FIFO is empty.
- R4: While control bit 8 (offset 0x60) is set, no byte is offered to the shifter. Once the bit is cleared, the transmit FIFO drains completely.
- R5: The status word at 0x64 reads {transmit full, transmit empty, receive full, receive empty} in bits [3:0], with all other bits zero. Writes to it have no effect.
- R6: A read at 0x6C while the receive FIFO is empty returns 0xDEADBEEF and leaves the FIFO unchanged.
- R7: A byte that returns while the receive FIFO is full is dropped, and evt_rx_overrun pulses for one cycle.
- R8: Writing control bit 5 empties the transmit FIFO and writing bit 6 empties the receive FIFO. Both bits read back as 0. The other control bits are stored as written.
- R9: Writing 0xA to offset 0x40 returns every register and both FIFOs to their reset state. Any other value written there has no effect.
- R10: ss_n[i] follows bit i of the register at offset 0x70, which resets to all ones.
- R11: Each FIFO holds DEPTH bytes. A transmit write made while the transmit FIFO is full is dropped.
- R12: evt_rx_full pulses once when a push fills the receive FIFO. evt_tx_empty pulses once when a handshake takes the last transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid on the next cycle |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter accepts tx_byte |
| tx_byte | output | 8 | Byte to shift out |
| rx_valid | input | 1 | Shifter returns a byte |
| rx_byte | input | 8 | Byte shifted in |
| ss_n | output | NUM_SS | Active-low slave selects |
| evt_rx_overrun | output | 1 | Pulse: a returned byte was dropped |
| evt_rx_full | output | 1 | Pulse: the receive FIFO became full |
| evt_tx_empty | output | 1 | Pulse: the last transmit byte was handed over |

## Verification
The bench sweeps every burst length from one byte up to the full FIFO depth. Each burst is queued under inhibit and then released, which separates off-by-one errors in occupancy, in the full flag and in the drain count from plain ordering errors. A burst of one byte more than the receive depth, sent with the master enabled, checks that only the surplus byte is dropped and that the overrun is reported exactly once. Further patterns cover the single-FIFO reset bits, a wrong key against the right key, and select masks with mixed bit values, so that each one shows which state a given write may touch.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    localparam logic [4:0] W_SOFTRST = 5'h10;
    localparam logic [4:0] W_CTRL    = 5'h18;
    localparam logic [4:0] W_STAT    = 5'h19;
    localparam logic [4:0] W_TXDATA  = 5'h1A;
    localparam logic [4:0] W_RXDATA  = 5'h1B;
    localparam logic [4:0] W_SELECT  = 5'h1C;
    localparam logic [4:0] W_TXOCC   = 5'h1D;
    localparam logic [4:0] W_RXOCC   = 5'h1E;

    localparam logic [31:0] RESET_KEY    = 32'h0000_000A;
    localparam logic [31:0] EMPTY_MARKER = 32'hDEAD_BEEF;

    localparam int CTRL_TXCLR   = 5;
    localparam int CTRL_RXCLR   = 6;
    localparam int CTRL_INHIBIT = 8;

    typedef struct packed {
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } fill_status_t;

    function automatic logic [31:0] occ_word(input logic [31:0] cnt);
        return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 256
) (
    input  logic                           clk,
    input  logic                           clr,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (clr)
        count <= CAP);

    a_r11_full_blocks_growth: assert property (@(posedge clk) disable iff (clr)
        (full && !pop) |=> (count == CAP));

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       inhibit,
    input  logic       tx_empty,
    input  logic [7:0] tx_head,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       tx_pop,
    output logic       rx_push,
    output logic [7:0] rx_data
);
    logic busy;

    assign tx_valid = !inhibit && !busy && !tx_empty;
    assign tx_byte  = tx_head;
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_push  = busy && rx_valid;
    assign rx_data  = rx_byte;

    always_ff @(posedge clk) begin
        if (rst)          busy <= 1'b0;
        else if (tx_pop)  busy <= 1'b1;
        else if (rx_push) busy <= 1'b0;
    end

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);

endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
    import spi_mm_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int NUM_SS = 1,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [NUM_SS-1:0] ss_n,
    output logic              evt_rx_overrun,
    output logic              evt_rx_full,
    output logic              evt_tx_empty
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] ONE_LEFT = CW'(DEPTH - 1);

    logic [4:0]  word;
    logic        soft_hit, blk_rst;
    logic [31:0] ctrl_q, sel_q;
    logic        tx_clr, rx_clr, tx_push, rx_pop;
    logic        tx_pop, rx_push;
    logic [7:0]  tx_head, rx_head, rx_data;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_count, rx_count;
    fill_status_t stat;
    logic [31:0] rd_mux;

    assign word     = addr[6:2];
    assign soft_hit = wr_en && (word == W_SOFTRST) && (wdata == RESET_KEY);
    assign blk_rst  = rst || soft_hit;

    assign tx_clr  = blk_rst || (wr_en && word == W_CTRL && wdata[CTRL_TXCLR]);
    assign rx_clr  = blk_rst || (wr_en && word == W_CTRL && wdata[CTRL_RXCLR]);
    assign tx_push = wr_en && (word == W_TXDATA);
    assign rx_pop  = rd_en && (word == W_RXDATA) && !rx_empty;

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            ctrl_q <= '0;
            sel_q  <= '1;
        end else if (wr_en) begin
            if (word == W_CTRL) begin
                ctrl_q <= wdata;
                ctrl_q[CTRL_TXCLR] <= 1'b0;
                ctrl_q[CTRL_RXCLR] <= 1'b0;
            end
            if (word == W_SELECT) sel_q <= wdata;
        end
    end

    assign ss_n = sel_q[NUM_SS-1:0];

    spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .clr(tx_clr), .push(tx_push), .din(wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .count(tx_count)
    );

    spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .clr(rx_clr), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
        .count(rx_count)
    );

    spi_xfer_seq u_seq (
        .clk(clk), .rst(blk_rst), .inhibit(ctrl_q[CTRL_INHIBIT]),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_data)
    );

    always_comb begin
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_full  = rx_full;
        stat.rx_empty = rx_empty;
        case (word)
            W_CTRL:   rd_mux = ctrl_q;
            W_STAT:   rd_mux = {28'd0, stat};
            W_RXDATA: rd_mux = rx_empty ? EMPTY_MARKER : {24'd0, rx_head};
            W_SELECT: rd_mux = sel_q;
            W_TXOCC:  rd_mux = occ_word(32'(tx_count));
            W_RXOCC:  rd_mux = occ_word(32'(rx_count));
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            evt_rx_overrun <= 1'b0;
            evt_rx_full    <= 1'b0;
            evt_tx_empty   <= 1'b0;
        end else begin
            evt_rx_overrun <= rx_push && rx_full && !rx_clr;
            evt_rx_full    <= rx_push && !rx_full && !rx_pop && !rx_clr
                              && (rx_count == ONE_LEFT);
            evt_tx_empty   <= tx_pop && !tx_push && !tx_clr
                              && (tx_count == CW'(1));
        end
    end

    a_r4_inhibit_stops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == W_CTRL && wdata[CTRL_INHIBIT]) |=> !tx_valid);

    a_r6_empty_marker: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word == W_RXDATA && rx_empty) |=> (rdata == EMPTY_MARKER));

    a_r7_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_push && rx_full && !rx_clr) |=> evt_rx_overrun);

    a_r9_key_reset: assert property (@(posedge clk) disable iff (rst)
        soft_hit |=> (ss_n == '1 && rx_empty && tx_empty && !tx_valid));

    a_r10_select_follow: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == W_SELECT) |=> (ss_n == $past(wdata[NUM_SS-1:0])));

endmodule

// File: tb/spi_mm_ctrl_tb_top.sv
module spi_mm_ctrl_tb_top;
    localparam int DEPTH  = 4;
    localparam int NUM_SS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [NUM_SS-1:0] ss_n;
    logic        evt_rx_overrun, evt_rx_full, evt_tx_empty;

    int n_checks = 0, n_fails = 0;
    int n_ovr = 0, n_rxf = 0, n_txe = 0;
    logic [7:0] sent_q [64];
    int sent_n = 0;
    logic pend = 1'b0;
    logic [7:0] pend_b = '0;

    always #4 clk = ~clk;

    spi_mm_ctrl #(.DEPTH(DEPTH), .NUM_SS(NUM_SS), .ADDR_W(7)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .ss_n(ss_n),
        .evt_rx_overrun(evt_rx_overrun), .evt_rx_full(evt_rx_full),
        .evt_tx_empty(evt_tx_empty)
    );

    function automatic logic [7:0] echo(input logic [7:0] b);
        return b ^ 8'h5A;
    endfunction

    // shifter model: returns echo(byte) one cycle after the handshake
    always @(negedge clk) begin
        if (pend) begin
            rx_valid = 1'b1;
            rx_byte  = echo(pend_b);
            pend     = 1'b0;
        end else begin
            rx_valid = 1'b0;
        end
        if (!rst && tx_valid && tx_ready) begin
            if (sent_n < 64) sent_q[sent_n] = tx_byte;
            sent_n = sent_n + 1;
            pend   = 1'b1;
            pend_b = tx_byte;
        end
        if (!rst) begin
            if (evt_rx_overrun) n_ovr = n_ovr + 1;
            if (evt_rx_full)    n_rxf = n_rxf + 1;
            if (evt_tx_empty)   n_txe = n_txe + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks = n_checks + 1;
        n_fails  = n_fails + 1;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        rd(7'h64, v); chk(v == 32'h5, "R1 status", v, 32'h5);
        rd(7'h60, v); chk(v == 32'h0, "R1 control", v, 32'h0);
        rd(7'h74, v); chk(v == 32'h0, "R1 tx occupancy", v, 32'h0);
        rd(7'h78, v); chk(v == 32'h0, "R1 rx occupancy", v, 32'h0);
        chk(ss_n == 3'b111, "R1 selects", 32'(ss_n), 32'h7);

        // R6 empty read marker, no change
        rd(7'h6C, v); chk(v == 32'hDEADBEEF, "R6 marker", v, 32'hDEADBEEF);
        rd(7'h78, v); chk(v == 32'h0, "R6 rx occupancy unchanged", v, 32'h0);

        // R4 inhibit holds, R2 low byte only, R11 full drop
        wr(7'h60, 32'h100);
        wr(7'h68, 32'h111); wr(7'h68, 32'h1A2); wr(7'h68, 32'h33);
        idle(4);
        chk(sent_n == 0, "R4 no transfer while inhibited", 32'(sent_n), 0);
        rd(7'h74, v); chk(v == 32'h2, "R3 tx occupancy 3", v, 32'h2);
        rd(7'h64, v); chk(v == 32'h1, "R5 status partial tx", v, 32'h1);
        wr(7'h68, 32'h44); wr(7'h68, 32'h55);
        rd(7'h64, v); chk(v == 32'h9, "R11 tx full status", v, 32'h9);
        rd(7'h74, v); chk(v == 32'h3, "R11 dropped write", v, 32'h3);
        wr(7'h60, 32'h0);
        idle(12);
        chk(sent_n == 4, "R4 drain count", 32'(sent_n), 4);
        chk(sent_q[0] == 8'h11 && sent_q[1] == 8'hA2 && sent_q[2] == 8'h33
            && sent_q[3] == 8'h44, "R2 order and low byte",
            {sent_q[0], sent_q[1], sent_q[2], sent_q[3]}, 32'h11A23344);
        rd(7'h64, v); chk(v == 32'h6, "R5 status after drain", v, 32'h6);
        chk(n_rxf == 1 && n_txe == 1, "R12 event pulses", 32'(n_rxf*16 + n_txe), 32'h11);
        rd(7'h6C, v); chk(v == 32'(echo(8'h11)), "R3 rx first", v, 32'(echo(8'h11)));
        rd(7'h6C, v); chk(v == 32'(echo(8'hA2)), "R3 rx second", v, 32'(echo(8'hA2)));
        rd(7'h78, v); chk(v == 32'h1, "R3 rx occupancy", v, 32'h1);
        rd(7'h6C, v); rd(7'h6C, v);
        chk(v == 32'(echo(8'h44)), "R3 rx last", v, 32'(echo(8'h44)));

        // R7 overrun with master enabled
        base = sent_n;
        for (int k = 0; k < DEPTH + 1; k++) begin
            wr(7'h68, 32'(8'h80 + k));
            idle(3);
        end
        chk(sent_n == base + DEPTH + 1, "R2 direct sends", 32'(sent_n), 32'(base + DEPTH + 1));
        chk(n_ovr == 1, "R7 overrun event", 32'(n_ovr), 1);
        rd(7'h78, v); chk(v == 32'(DEPTH - 1), "R7 rx stays full", v, 32'(DEPTH - 1));
        for (int k = 0; k < DEPTH; k++) begin
            rd(7'h6C, v);
            chk(v == 32'(echo(8'(8'h80 + k))), "R7 kept bytes", v, 32'(echo(8'(8'h80 + k))));
        end

        // R8 one-shot FIFO clears
        wr(7'h68, 32'h01); wr(7'h68, 32'h02);
        idle(6);
        wr(7'h60, 32'h100);
        wr(7'h68, 32'h03); wr(7'h68, 32'h04);
        rd(7'h64, v); chk(v == 32'h0, "R5 both partial", v, 32'h0);
        wr(7'h60, 32'h120);
        rd(7'h64, v); chk(v == 32'h4, "R8 tx cleared only", v, 32'h4);
        rd(7'h60, v); chk(v == 32'h100, "R8 bits read zero", v, 32'h100);
        wr(7'h60, 32'h140);
        rd(7'h64, v); chk(v == 32'h5, "R8 rx cleared", v, 32'h5);

        // R5 status write ignored
        wr(7'h68, 32'h07);
        wr(7'h64, 32'hF);
        rd(7'h64, v); chk(v == 32'h1, "R5 write ignored", v, 32'h1);

        // R10 selects
        wr(7'h70, 32'h5);
        chk(ss_n == 3'b101, "R10 mask 101", 32'(ss_n), 32'h5);
        wr(7'h70, 32'h2);
        chk(ss_n == 3'b010, "R10 mask 010", 32'(ss_n), 32'h2);

        // R9 keyed reset
        wr(7'h40, 32'h5);
        chk(ss_n == 3'b010, "R9 wrong key selects", 32'(ss_n), 32'h2);
        rd(7'h60, v); chk(v == 32'h100, "R9 wrong key control", v, 32'h100);
        rd(7'h74, v); chk(v == 32'h0, "R9 wrong key tx kept", v, 32'h0);
        rd(7'h64, v); chk(v == 32'h1, "R9 wrong key status", v, 32'h1);
        wr(7'h40, 32'hA);
        chk(ss_n == 3'b111, "R9 key selects", 32'(ss_n), 32'h7);
        rd(7'h60, v); chk(v == 32'h0, "R9 key control", v, 32'h0);
        rd(7'h64, v); chk(v == 32'h5, "R9 key status", v, 32'h5);

        // sweep of burst lengths
        for (int n = 1; n <= DEPTH; n++) begin
            wr(7'h60, 32'h100);
            for (int k = 0; k < n; k++) wr(7'h68, 32'(n * 16 + k));
            rd(7'h74, v); chk(v == 32'(n - 1), "R3 sweep tx occupancy", v, 32'(n - 1));
            rd(7'h64, v);
            chk(v == ((n == DEPTH) ? 32'h9 : 32'h1), "R5 sweep tx status", v,
                (n == DEPTH) ? 32'h9 : 32'h1);
            wr(7'h60, 32'h0);
            idle(3 * DEPTH + 4);
            rd(7'h78, v); chk(v == 32'(n - 1), "R3 sweep rx occupancy", v, 32'(n - 1));
            rd(7'h64, v);
            chk(v == ((n == DEPTH) ? 32'h6 : 32'h4), "R5 sweep rx status", v,
                (n == DEPTH) ? 32'h6 : 32'h4);
            for (int k = 0; k < n; k++) begin
                rd(7'h6C, v);
                chk(v == 32'(echo(8'(n * 16 + k))), "R3 sweep data", v,
                    32'(echo(8'(n * 16 + k))));
            end
            rd(7'h64, v); chk(v == 32'h5, "R5 sweep empty", v, 32'h5);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule